// File: doc/BRIEF.md
# Cache Error Trap Enable Router

This block sits between the error detectors of a second-level cache and the system bus interface on one side and a processor core's trap logic on the other. Each cycle it accepts up to `EVT_PORTS` error events. Every event carries an error class and the kind of access that was under way when the error was detected. From the class, the access kind and a software-written enable register, the block decides which of four trap request lines to pulse: a precise instruction-access fault, a precise data-access fault, a disrupting ECC trap, or a fast cache-ECC trap.

Logging does not depend on the enables. A sticky status register records every detected event in a bit chosen by class and access kind, whether or not a trap was raised. Software clears status bits by writing ones to them. The enable register also holds controls that force the tag and data check bits. These are driven out to the ECC logic, which lies outside this block.

Class codes on `evtClass`: 0 cache soft-correctable, 1 cache uncorrectable, 2 bus data uncorrectable, 3 tag uncorrectable, 4 bus timeout, 5 bus error reply, 6 data corrected by hardware, 7 tag corrected by hardware. Access codes on `evtAccess`: 0 instruction fetch, 1 data load, 2 atomic, 3 store merge, 4 writeback, 5 copyout, 6 and 7 reserved. Register address 0 selects the enable register and address 1 selects the status register.

Top module: `errTrapRouter`

## Requirements
- R1: While reset is asserted, and after it is released, the enable register and the status register read zero and all four trap outputs are low.
- R2: The enable register (address 0) keeps bits 0, 1 and 3..18 of a write and reads zero in bit 2 and in bits 19 and above. Bit 18 drives `forceTagEcc`, bits 17:14 drive `forceTagVal`, bit 13 drives `forceDataEcc` and bits 12:4 drive `forceDataVal`.
- R3: Each valid event sets status bit `cls` when its access code is 0..2 and bit `8+cls` when its access code is 3..7. This happens whatever the enables hold, and the bit reads back at address 1 in the cycle after the event.
- R4: Writing address 1 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: When an event sets a status bit in the same cycle that a write-1 clears that bit, the bit ends up set.
- R6: With enable bit 3 set, class 0 or 1 on access code 0, 1 or 2 pulses `trapFast`.
- R7: Class 0 or 1 on access code 3, 4 or 5 never pulses `trapFast`, whatever the enables hold.
- R8: With enable bit 1 set, class 2..5 pulses `trapInstr` on access 0, `trapData` on access 1 or 2, and `trapDisrupt` on access 3, 4 or 5.
- R9: With enable bit 0 set, class 6 or 7 on any access code 0..5 pulses `trapDisrupt`.
- R10: With the matching enable bit clear, an event raises no trap. The trap decision uses the enable value held before any write in the same cycle.
- R11: Each trap output rises in the cycle after the event and stays high for one cycle unless another event follows. When several ports report events in one cycle, each trap line that any of them calls for is raised.
- R12: Events on the reserved access codes 6 and 7 raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 enable, 1 status |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data of the selected register, combinational |
| evtValid | input | EVT_PORTS | One valid bit per event port |
| evtClass | input | EVT_PORTS*3 | Error class per port, port p at bits [3p+2:3p] |
| evtAccess | input | EVT_PORTS*3 | Access kind per port, port p at bits [3p+2:3p] |
| trapInstr | output | 1 | Instruction-access fault request pulse |
| trapData | output | 1 | Data-access fault request pulse |
| trapDisrupt | output | 1 | Disrupting ECC trap request pulse |
| trapFast | output | 1 | Fast cache-ECC trap request pulse |
| forceTagEcc | output | 1 | Force tag check bits |
| forceTagVal | output | 4 | Forced tag check value |
| forceDataEcc | output | 1 | Force data check bits |
| forceDataVal | output | 9 | Forced data check value |

## Verification
All 64 pairings of class and access code are driven one at a time under five enable settings: all clear, each single trap enable, and all three together. This separates a routing fault (the wrong trap line for one class and access pair) from a gating fault (a trap leaking past a clear enable). The status bit read back after each event shows whether logging stays independent of the enables and whether the read/background split of the status map is correct. Paired events on both ports in one cycle show that trap lines merge rather than override each other. Register writes that coincide with events show whether the enable value from before the write is used and whether a set wins over a write-1 clear.

// File: rtl/errTrapPkg.sv
package errTrapPkg;

  localparam int CLASS_W     = 3;
  localparam int ACC_W       = 3;
  localparam int NUM_CLASSES = 1 << CLASS_W;
  localparam int STAT_W      = 2 * NUM_CLASSES;
  localparam int STAT_IDX_W  = CLASS_W + 1;

  // enable register layout
  localparam int EN_W            = 19;
  localparam int EN_CORR_BIT     = 0;
  localparam int EN_UNCORR_BIT   = 1;
  localparam int EN_FAST_BIT     = 3;
  localparam int DATA_VAL_LSB    = 4;
  localparam int DATA_VAL_W      = 9;
  localparam int DATA_FORCE_BIT  = DATA_VAL_LSB + DATA_VAL_W;
  localparam int TAG_VAL_LSB     = DATA_FORCE_BIT + 1;
  localparam int TAG_VAL_W       = 4;
  localparam int TAG_FORCE_BIT   = TAG_VAL_LSB + TAG_VAL_W;
  localparam logic [EN_W-1:0] EN_WRITABLE = ~(EN_W'(1) << 2);

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef enum logic [CLASS_W-1:0] {
    CLS_CACHE_SOFT   = 3'd0,
    CLS_CACHE_UNCORR = 3'd1,
    CLS_BUS_UNCORR   = 3'd2,
    CLS_TAG_UNCORR   = 3'd3,
    CLS_BUS_TIMEOUT  = 3'd4,
    CLS_BUS_FAULT    = 3'd5,
    CLS_DATA_CORR    = 3'd6,
    CLS_TAG_CORR     = 3'd7
  } errClass_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH     = 3'd0,
    ACC_LOAD      = 3'd1,
    ACC_ATOMIC    = 3'd2,
    ACC_MERGE     = 3'd3,
    ACC_WRITEBACK = 3'd4,
    ACC_COPYOUT   = 3'd5,
    ACC_RSVD6     = 3'd6,
    ACC_RSVD7     = 3'd7
  } accType_e;

  typedef struct packed {
    logic fast;
    logic disrupt;
    logic data;
    logic instr;
  } trapVec_t;

  localparam int TRAP_W = $bits(trapVec_t);

  typedef struct packed {
    logic              enWr;
    logic [STAT_W-1:0] stClr;
    logic [STAT_W-1:0] stSet;
    trapVec_t          trapReq;
  } ctrlStrobes_t;

endpackage

// File: rtl/errTrapDecode.sv
module errTrapDecode
  import errTrapPkg::*;
(
  input  logic               evtValid,
  input  logic [CLASS_W-1:0] evtClass,
  input  logic [ACC_W-1:0]   evtAccess,
  input  logic               enCorr,
  input  logic               enUncorr,
  input  logic               enFast,
  output trapVec_t           trapReq,
  output logic [STAT_W-1:0]  statusSet
);

  errClass_e             cls;
  accType_e              acc;
  logic                  isRead;
  logic                  isBackground;
  logic                  isCacheErr;
  logic                  isSysUncorr;
  logic                  isCorrected;
  logic [STAT_IDX_W-1:0] statIdx;

  always_comb begin
    cls          = errClass_e'(evtClass);
    acc          = accType_e'(evtAccess);
    isRead       = acc inside {ACC_FETCH, ACC_LOAD, ACC_ATOMIC};
    isBackground = acc inside {ACC_MERGE, ACC_WRITEBACK, ACC_COPYOUT};
    isCacheErr   = cls inside {CLS_CACHE_SOFT, CLS_CACHE_UNCORR};
    isSysUncorr  = cls inside {CLS_BUS_UNCORR, CLS_TAG_UNCORR,
                               CLS_BUS_TIMEOUT, CLS_BUS_FAULT};
    isCorrected  = cls inside {CLS_DATA_CORR, CLS_TAG_CORR};
    // reads log in the low half, everything else in the high half
    statIdx      = {~isRead, evtClass};
  end

  always_comb begin
    trapReq   = '0;
    statusSet = '0;
    if (evtValid) begin
      statusSet[statIdx] = 1'b1;
      trapReq.fast    = enFast && isCacheErr && isRead;
      trapReq.instr   = enUncorr && isSysUncorr && (acc == ACC_FETCH);
      trapReq.data    = enUncorr && isSysUncorr &&
                        (acc == ACC_LOAD || acc == ACC_ATOMIC);
      trapReq.disrupt = (enUncorr && isSysUncorr && isBackground) ||
                        (enCorr && isCorrected && (isRead || isBackground));
    end
  end

endmodule

// File: rtl/errTrapCtrl.sv
module errTrapCtrl
  import errTrapPkg::*;
#(
  parameter int EVT_PORTS = 2
) (
  input  logic                         regWrEn,
  input  logic                         regAddr,
  input  logic [STAT_W-1:0]            regWrLow,
  input  logic [EVT_PORTS-1:0]         evtValid,
  input  logic [EVT_PORTS*CLASS_W-1:0] evtClass,
  input  logic [EVT_PORTS*ACC_W-1:0]   evtAccess,
  input  logic                         enCorr,
  input  logic                         enUncorr,
  input  logic                         enFast,
  output ctrlStrobes_t                 strobes
);

  trapVec_t          trapPort [EVT_PORTS];
  logic [STAT_W-1:0] setPort  [EVT_PORTS];

  for (genvar p = 0; p < EVT_PORTS; p++) begin : gPort
    errTrapDecode uDecode (
      .evtValid  (evtValid[p]),
      .evtClass  (evtClass[p*CLASS_W +: CLASS_W]),
      .evtAccess (evtAccess[p*ACC_W +: ACC_W]),
      .enCorr    (enCorr),
      .enUncorr  (enUncorr),
      .enFast    (enFast),
      .trapReq   (trapPort[p]),
      .statusSet (setPort[p])
    );
  end

  logic [TRAP_W-1:0] trapAcc;
  logic [STAT_W-1:0] setAcc;

  always_comb begin
    trapAcc = '0;
    setAcc  = '0;
    for (int p = 0; p < EVT_PORTS; p++) begin
      trapAcc = trapAcc | trapPort[p];
      setAcc  = setAcc | setPort[p];
    end
  end

  always_comb begin
    strobes.enWr    = regWrEn && (regAddr == ADDR_ENABLE);
    strobes.stClr   = (regWrEn && (regAddr == ADDR_STATUS)) ? regWrLow : '0;
    strobes.stSet   = setAcc;
    strobes.trapReq = trapVec_t'(trapAcc);
  end

endmodule

// File: rtl/errTrapDatapath.sv
module errTrapDatapath
  import errTrapPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [EN_W-1:0]       regWrLow,
  input  logic                  regAddr,
  output logic [DATA_W-1:0]     regRdData,
  output logic [EN_W-1:0]       enableQ,
  output logic [STAT_W-1:0]     statusQ,
  output trapVec_t              trapQ,
  output logic                  forceTagEcc,
  output logic [TAG_VAL_W-1:0]  forceTagVal,
  output logic                  forceDataEcc,
  output logic [DATA_VAL_W-1:0] forceDataVal
);

  localparam int EN_PAD   = DATA_W - EN_W;
  localparam int STAT_PAD = DATA_W - STAT_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      trapQ   <= '0;
    end else begin
      if (strobes.enWr) begin
        enableQ <= regWrLow & EN_WRITABLE;
      end
      // set has priority over a same-cycle write-1 clear
      statusQ <= (statusQ & ~strobes.stClr) | strobes.stSet;
      trapQ   <= strobes.trapReq;
    end
  end

  always_comb begin
    if (regAddr == ADDR_STATUS) begin
      regRdData = {{STAT_PAD{1'b0}}, statusQ};
    end else begin
      regRdData = {{EN_PAD{1'b0}}, enableQ};
    end
  end

  assign forceTagEcc  = enableQ[TAG_FORCE_BIT];
  assign forceTagVal  = enableQ[TAG_VAL_LSB +: TAG_VAL_W];
  assign forceDataEcc = enableQ[DATA_FORCE_BIT];
  assign forceDataVal = enableQ[DATA_VAL_LSB +: DATA_VAL_W];

endmodule

// File: rtl/errTrapRouter.sv
module errTrapRouter
  import errTrapPkg::*;
#(
  parameter int EVT_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic                         regAddr,
  input  logic [DATA_W-1:0]            regWrData,
  output logic [DATA_W-1:0]            regRdData,
  input  logic [EVT_PORTS-1:0]         evtValid,
  input  logic [EVT_PORTS*CLASS_W-1:0] evtClass,
  input  logic [EVT_PORTS*ACC_W-1:0]   evtAccess,
  output logic                         trapInstr,
  output logic                         trapData,
  output logic                         trapDisrupt,
  output logic                         trapFast,
  output logic                         forceTagEcc,
  output logic [TAG_VAL_W-1:0]         forceTagVal,
  output logic                         forceDataEcc,
  output logic [DATA_VAL_W-1:0]        forceDataVal
);

  ctrlStrobes_t      strobes;
  logic [EN_W-1:0]   enableQ;
  logic [STAT_W-1:0] statusQ;
  trapVec_t          trapQ;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:EN_W];

  errTrapCtrl #(
    .EVT_PORTS (EVT_PORTS)
  ) uCtrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrLow  (regWrData[STAT_W-1:0]),
    .evtValid  (evtValid),
    .evtClass  (evtClass),
    .evtAccess (evtAccess),
    .enCorr    (enableQ[EN_CORR_BIT]),
    .enUncorr  (enableQ[EN_UNCORR_BIT]),
    .enFast    (enableQ[EN_FAST_BIT]),
    .strobes   (strobes)
  );

  errTrapDatapath #(
    .DATA_W (DATA_W)
  ) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regWrLow     (regWrData[EN_W-1:0]),
    .regAddr      (regAddr),
    .regRdData    (regRdData),
    .enableQ      (enableQ),
    .statusQ      (statusQ),
    .trapQ        (trapQ),
    .forceTagEcc  (forceTagEcc),
    .forceTagVal  (forceTagVal),
    .forceDataEcc (forceDataEcc),
    .forceDataVal (forceDataVal)
  );

  assign trapInstr   = trapQ.instr;
  assign trapData    = trapQ.data;
  assign trapDisrupt = trapQ.disrupt;
  assign trapFast    = trapQ.fast;

endmodule

// File: rtl/errTrapChecker.sv
module errTrapChecker
  import errTrapPkg::*;
#(
  parameter int EVT_PORTS = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         regWrEn,
  input logic                         regAddr,
  input logic [STAT_W-1:0]            regWrLow,
  input logic [EVT_PORTS-1:0]         evtValid,
  input logic [EVT_PORTS*CLASS_W-1:0] evtClass,
  input logic [EVT_PORTS*ACC_W-1:0]   evtAccess,
  input logic                         enCorr,
  input logic                         enUncorr,
  input logic                         enFast,
  input logic [STAT_W-1:0]            statusQ,
  input logic [EN_W-1:0]              enableQ,
  input logic                         trapInstr,
  input logic                         trapData,
  input logic                         trapDisrupt,
  input logic                         trapFast
);

  logic [STAT_W-1:0] clrMask;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] keepQ;
  logic [STAT_W-1:0] setQ;
  logic [STAT_W-1:0] clrQ;

  always_comb begin
    clrMask = (regWrEn && regAddr == ADDR_STATUS) ? regWrLow : '0;
    setMask = '0;
    for (int p = 0; p < EVT_PORTS; p++) begin
      if (evtValid[p]) begin
        setMask[{(evtAccess[p*ACC_W +: ACC_W] > 3'd2),
                 evtClass[p*CLASS_W +: CLASS_W]}] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepQ <= '0;
      setQ  <= '0;
      clrQ  <= '0;
    end else begin
      keepQ <= statusQ & ~clrMask;
      setQ  <= setMask;
      clrQ  <= clrMask;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (statusQ == '0 && enableQ == '0 &&
               !trapInstr && !trapData && !trapDisrupt && !trapFast));

  assert_logged_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & setQ) == setQ);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (keepQ & ~statusQ) == '0);

  assert_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~(keepQ | setQ)) == '0);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & setQ & clrQ) == (setQ & clrQ));

  assert_fast_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapFast |-> $past(enFast));

  assert_instr_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapInstr |-> $past(enUncorr));

  assert_data_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapData |-> $past(enUncorr));

  assert_disrupt_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapDisrupt |-> $past(enCorr || enUncorr));

  assert_trap_follows_event_R11: assert property (@(posedge clk) disable iff (!rstN)
    (trapInstr || trapData || trapDisrupt || trapFast) |-> $past(|evtValid));

endmodule

bind errTrapRouter errTrapChecker #(
  .EVT_PORTS (EVT_PORTS)
) uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrLow    (regWrData[errTrapPkg::STAT_W-1:0]),
  .evtValid    (evtValid),
  .evtClass    (evtClass),
  .evtAccess   (evtAccess),
  .enCorr      (enableQ[errTrapPkg::EN_CORR_BIT]),
  .enUncorr    (enableQ[errTrapPkg::EN_UNCORR_BIT]),
  .enFast      (enableQ[errTrapPkg::EN_FAST_BIT]),
  .statusQ     (statusQ),
  .enableQ     (enableQ),
  .trapInstr   (trapInstr),
  .trapData    (trapData),
  .trapDisrupt (trapDisrupt),
  .trapFast    (trapFast)
);

// File: tb/tb_errTrapRouter.sv
`timescale 1ns/1ps
module tb_errTrapRouter;

  localparam int EVT_PORTS = 2;
  localparam int DATA_W    = 32;
  localparam int WATCHDOG_CYCLES = 100000;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   regWrEn = 1'b0;
  logic                   regAddr = 1'b0;
  logic [DATA_W-1:0]      regWrData = '0;
  logic [DATA_W-1:0]      regRdData;
  logic [EVT_PORTS-1:0]   evtValid = '0;
  logic [EVT_PORTS*3-1:0] evtClass = '0;
  logic [EVT_PORTS*3-1:0] evtAccess = '0;
  logic                   trapInstr, trapData, trapDisrupt, trapFast;
  logic                   forceTagEcc, forceDataEcc;
  logic [3:0]             forceTagVal;
  logic [8:0]             forceDataVal;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  errTrapRouter #(.EVT_PORTS(EVT_PORTS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtValid(evtValid),
    .evtClass(evtClass), .evtAccess(evtAccess), .trapInstr(trapInstr),
    .trapData(trapData), .trapDisrupt(trapDisrupt), .trapFast(trapFast),
    .forceTagEcc(forceTagEcc), .forceTagVal(forceTagVal),
    .forceDataEcc(forceDataEcc), .forceDataVal(forceDataVal)
  );

  function automatic void check(string tag, string what, longint actual, longint expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, actual, expected);
    end
  endfunction

  // expected traps as {fast, disrupt, data, instr}
  function automatic logic [3:0] expTraps(logic [3:0] en, int cls, int acc);
    logic [3:0] t = 4'b0;
    if (cls <= 1 && en[3] && acc <= 2) t[3] = 1'b1;
    if (cls >= 2 && cls <= 5 && en[1]) begin
      if (acc == 0) t[0] = 1'b1;
      else if (acc <= 2) t[1] = 1'b1;
      else if (acc <= 5) t[2] = 1'b1;
    end
    if (cls >= 6 && en[0] && acc <= 5) t[2] = 1'b1;
    return t;
  endfunction

  function automatic int statBit(int cls, int acc);
    return (acc <= 2) ? cls : 8 + cls;
  endfunction

  function automatic string trapTag(int cls, int acc);
    if (acc >= 6) return "R12";
    if (cls <= 1) return (acc <= 2) ? "R6" : "R7";
    if (cls <= 5) return "R8";
    return "R9";
  endfunction

  function automatic logic [3:0] trapsNow();
    return {trapFast, trapDisrupt, trapData, trapInstr};
  endfunction

  task automatic writeReg(input logic a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic fireOne(input logic [3:0] en, input int cls, input int acc);
    @(negedge clk);
    evtValid = 2'b01; evtClass = 6'(cls); evtAccess = 6'(acc); regAddr = 1'b1;
    @(negedge clk);
    evtValid = '0;
    check(trapTag(cls, acc), $sformatf("traps en=%0h cls=%0d acc=%0d", en, cls, acc),
          trapsNow(), expTraps(en, cls, acc));
    check("R3", $sformatf("status cls=%0d acc=%0d", cls, acc),
          regRdData, 64'(1) << statBit(cls, acc));
    @(negedge clk);
    check("R11", "trap pulse ends", trapsNow(), 0);
    writeReg(1'b1, 32'h0000_FFFF);
  endtask

  task automatic testReset();
    logic [DATA_W-1:0] d;
    readReg(1'b0, d); check("R1", "enable after reset", d, 0);
    readReg(1'b1, d); check("R1", "status after reset", d, 0);
    check("R1", "traps after reset", trapsNow(), 0);
  endtask

  task automatic testEnableReg();
    logic [DATA_W-1:0] d;
    writeReg(1'b0, 32'hFFFF_FFFF);
    readReg(1'b0, d); check("R2", "writable mask", d, 32'h0007_FFFB);
    writeReg(1'b0, (32'd1 << 18) | (32'hA << 14) | (32'h15A << 4));
    readReg(1'b0, d);
    check("R2", "forceTagEcc", forceTagEcc, 1);
    check("R2", "forceTagVal", forceTagVal, 4'hA);
    check("R2", "forceDataEcc", forceDataEcc, 0);
    check("R2", "forceDataVal", forceDataVal, 9'h15A);
    writeReg(1'b0, 32'h0000_2000);
    readReg(1'b0, d);
    check("R2", "forceDataEcc set", forceDataEcc, 1);
    check("R2", "forceTagEcc clear", forceTagEcc, 0);
  endtask

  task automatic testSweep();
    logic [3:0] enList [5] = '{4'h0, 4'h1, 4'h2, 4'h8, 4'hB};
    for (int e = 0; e < 5; e++) begin
      writeReg(1'b0, 32'(enList[e]));
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 8; a++) begin
          fireOne(enList[e], c, a);
        end
      end
    end
  endtask

  task automatic testMultiPort();
    logic [DATA_W-1:0] d;
    writeReg(1'b0, 32'hB);
    @(negedge clk);
    evtValid = 2'b11;
    evtClass = {3'd2, 3'd1}; evtAccess = {3'd0, 3'd1};
    @(negedge clk);
    evtValid = '0;
    check("R11", "fast and instr together", trapsNow(), 4'b1001);
    readReg(1'b1, d); check("R3", "two ports logged", d, 32'h0006);
    writeReg(1'b1, 32'hFFFF);
    @(negedge clk);
    evtValid = 2'b11;
    evtClass = {3'd6, 3'd3}; evtAccess = {3'd1, 3'd4};
    @(negedge clk);
    evtValid = '0;
    check("R11", "two disrupt sources", trapsNow(), 4'b0100);
    writeReg(1'b1, 32'hFFFF);
  endtask

  task automatic testClear();
    logic [DATA_W-1:0] d;
    writeReg(1'b0, 32'h0);
    @(negedge clk);
    evtValid = 2'b11;
    evtClass = {3'd5, 3'd0}; evtAccess = {3'd4, 3'd0};
    @(negedge clk);
    evtValid = '0;
    readReg(1'b1, d); check("R3", "logged with enables clear", d, 32'h2001);
    writeReg(1'b1, 32'h0);
    readReg(1'b1, d); check("R4", "write of zero", d, 32'h2001);
    writeReg(1'b1, 32'h0001);
    readReg(1'b1, d); check("R4", "clear one bit", d, 32'h2000);
    writeReg(1'b1, 32'h2000);
    readReg(1'b1, d); check("R4", "clear last bit", d, 32'h0);
  endtask

  task automatic testCollision();
    logic [DATA_W-1:0] d;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 32'h0002;
    evtValid = 2'b01; evtClass = 6'd1; evtAccess = 6'd1;
    @(negedge clk);
    regWrEn = 1'b0; evtValid = '0;
    readReg(1'b1, d); check("R5", "set beats clear", d, 32'h0002);
    writeReg(1'b1, 32'hFFFF);
    readReg(1'b1, d); check("R4", "cleared after collision", d, 32'h0);
  endtask

  task automatic testOldEnable();
    logic [DATA_W-1:0] d;
    writeReg(1'b0, 32'h0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 32'hB;
    evtValid = 2'b01; evtClass = 6'd1; evtAccess = 6'd1;
    @(negedge clk);
    regWrEn = 1'b0; evtValid = '0;
    check("R10", "same-cycle enable write not used", trapsNow(), 0);
    readReg(1'b0, d); check("R10", "enable took write", d, 32'hB);
    @(negedge clk);
    evtValid = 2'b01; evtClass = 6'd1; evtAccess = 6'd1;
    @(negedge clk);
    evtValid = '0;
    check("R6", "fast after enable", trapsNow(), 4'b1000);
    writeReg(1'b1, 32'hFFFF);
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    check("R1", "traps during reset", trapsNow(), 0);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnableReg();
    testSweep();
    testMultiPort();
    testClear();
    testCollision();
    testOldEnable();
    finished = 1'b1;
    printSummary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL R11 watchdog: actual=running expected=done");
      printSummary();
      $finish;
    end
  end

endmodule